// File: doc/BRIEF.md
# Byte-Port Bus Glue with Wait States

This block sits between a 32-bit processor that sizes its bus per cycle and a group of 8-bit peripherals: a boot ROM, a RAM, a disk interface and a UART. It decodes the two highest address bits it is given into four active-low chip selects. It forms active-low read and write strobes, and it moves the single byte between the peripherals and the top lane of the processor data bus. Every cycle is answered as an 8-bit port, whatever size the processor requests.

The cycle ends through an acknowledge timed by a shift register. The register fills with ones on each clock while the address strobe is low, and it clears at once when the strobe is released. A tap picks the bit that drives the acknowledge. Memory regions (ROM, RAM) and I/O regions (disk, UART) each get their own tap, so each group has its own wait count.

The timer is a small phase machine with three states. IDLE holds while the address strobe is high. On a clock edge with the strobe low, the machine moves IDLE→WAIT, or IDLE→ACK if the chosen tap already reads one. It moves WAIT→ACK on the edge that fills the chosen tap, and it holds in ACK until the strobe rises. A rising strobe or the reset drops any state straight back to IDLE.

Top module: `byte_port_glue`

## Requirements
- R1: With the address strobe low, the region code `{addr_hi[1], addr_hi[0]}` selects exactly one low chip select: 00 ROM, 01 RAM, 10 disk, 11 UART.
- R2: While `as_n` is high, all four chip selects are high.
- R3: `rd_n` is low exactly when `ds_n` is low and `rw` is 1. `wr_n` is low exactly when `ds_n` is low and `rw` is 0. In every other case both are high.
- R4: `ack1_n` is always high.
- R5: The size request `siz` has no effect on any output.
- R6: `ack0_n` goes low after exactly T+1 rising clock edges sampled with `as_n` low. T is `MEM_TAP` for the ROM and RAM codes and `IO_TAP` for the disk and UART codes, each in the range 0..7.
- R7: `ack0_n` returns high without waiting for a clock edge when `as_n` rises, and the next cycle counts again from zero.
- R8: `per_wdata` equals `cpu_wdata[31:24]`. `cpu_rdata[31:24]` equals `per_rdata`, and `cpu_rdata[23:0]` is zero.
- R9: While `rst` is high, every chip select, strobe and acknowledge output is high.
- R10: Once `ack0_n` is low, it stays low for as long as `as_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous reset, active high |
| as_n | input | 1 | Address strobe, active low |
| ds_n | input | 1 | Data strobe, active low |
| rw | input | 1 | 1 = read, 0 = write |
| addr_hi | input | 2 | Region code, bit 1 the higher address bit |
| siz | input | 2 | Transfer size request (ignored) |
| cpu_wdata | input | 32 | Processor write data |
| per_rdata | input | 8 | Peripheral read byte |
| rom_cs_n | output | 1 | ROM select |
| ram_cs_n | output | 1 | RAM select |
| disk_cs_n | output | 1 | Disk interface select |
| uart_cs_n | output | 1 | UART select |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe |
| ack0_n | output | 1 | Low-order transfer acknowledge |
| ack1_n | output | 1 | High-order transfer acknowledge (held high) |
| per_wdata | output | 8 | Byte to peripherals |
| cpu_rdata | output | 32 | Read data, byte on the top lane |

## Verification
Assertions check the following on every clock:
- At most one chip select is low, and none is low while the strobe is released.
- The read and write strobes are never low together.
- The high acknowledge stays high.
- The low acknowledge appears only inside a strobed cycle and holds until the cycle ends.

Only the bench's scenarios can show the rest. These are the exact wait count for each region and tap, the restart after a released strobe, the independence from the size lines, byte-lane routing, and behaviour under reset.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_ACK  = 2'd2
    } phase_t;

    localparam int REGIONS = 4;
    localparam logic [1:0] RG_ROM  = 2'd0;
    localparam logic [1:0] RG_RAM  = 2'd1;
    localparam logic [1:0] RG_DISK = 2'd2;
    localparam logic [1:0] RG_UART = 2'd3;
endpackage

// File: rtl/bpg_decode.sv
module bpg_decode
    import bpg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 as_n,
    input  logic                 ds_n,
    input  logic                 rw,
    input  logic [1:0]           region,
    output logic [REGIONS-1:0]   cs_n,
    output logic                 rd_n,
    output logic                 wr_n
);
    for (genvar g = 0; g < REGIONS; g++) begin : g_cs
        assign cs_n[g] = rst | as_n | (region != g[1:0]);
    end

    always_comb begin
        rd_n = 1'b1;
        wr_n = 1'b1;
        if (!rst && !ds_n) begin
            rd_n = ~rw;
            wr_n = rw;
        end
    end

    p_one_select_r1: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);
    p_idle_selects_r2: assert property (@(posedge clk) disable iff (rst)
        as_n |-> (&cs_n));
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    p_strobe_needs_ds_r3: assert property (@(posedge clk) disable iff (rst)
        ds_n |-> (rd_n && wr_n));
endmodule

// File: rtl/bpg_wait.sv
module bpg_wait
    import bpg_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MEM_TAP = 1,
    parameter int IO_TAP  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic as_n,
    input  logic io_sel,
    output logic ack0_n
);
    localparam int TW = $clog2(DEPTH);

    phase_t             ph;
    logic [DEPTH-1:0]   sr;
    logic [DEPTH-1:0]   sr_nxt;
    logic [TW-1:0]      tap;

    assign tap    = io_sel ? IO_TAP[TW-1:0] : MEM_TAP[TW-1:0];
    assign sr_nxt = {sr[DEPTH-2:0], 1'b1};

    // State register: released strobe clears at once
    always_ff @(posedge clk or posedge as_n) begin
        if (as_n) begin
            sr <= '0;
            ph <= PH_IDLE;
        end else if (rst) begin
            sr <= '0;
            ph <= PH_IDLE;
        end else begin
            sr <= sr_nxt;
            ph <= sr_nxt[tap] ? PH_ACK : PH_WAIT;
        end
    end

    // Output decode
    always_comb begin
        ack0_n = 1'b1;
        unique case (ph)
            PH_IDLE: ack0_n = 1'b1;
            PH_WAIT: ack0_n = 1'b1;
            PH_ACK:  ack0_n = rst | as_n;
            default: ack0_n = 1'b1;
        endcase
    end

    p_ack_in_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        !ack0_n |-> !as_n);
    p_ack_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!ack0_n && !as_n) |=> (as_n || !ack0_n));
endmodule

// File: rtl/bpg_lane.sv
module bpg_lane #(
    parameter int BUS_W  = 32,
    parameter int BYTE_W = 8
) (
    input  logic [BUS_W-1:0]  cpu_wdata,
    input  logic [BYTE_W-1:0] per_rdata,
    output logic [BYTE_W-1:0] per_wdata,
    output logic [BUS_W-1:0]  cpu_rdata
);
    localparam int LO_W = BUS_W - BYTE_W;

    assign per_wdata = cpu_wdata[BUS_W-1 -: BYTE_W];
    assign cpu_rdata = {per_rdata, {LO_W{1'b0}}};
endmodule

// File: rtl/byte_port_glue.sv
module byte_port_glue
    import bpg_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int MEM_TAP = 1,
    parameter int IO_TAP  = 3,
    parameter int BUS_W   = 32,
    parameter int BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic [1:0]        addr_hi,
    input  logic [1:0]        siz,
    input  logic [BUS_W-1:0]  cpu_wdata,
    input  logic [BYTE_W-1:0] per_rdata,
    output logic              rom_cs_n,
    output logic              ram_cs_n,
    output logic              disk_cs_n,
    output logic              uart_cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ack0_n,
    output logic              ack1_n,
    output logic [BYTE_W-1:0] per_wdata,
    output logic [BUS_W-1:0]  cpu_rdata
);
    logic [REGIONS-1:0] cs_n;
    logic               siz_unused;

    assign siz_unused = ^siz;

    bpg_decode u_dec (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .region(addr_hi), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    bpg_wait #(.DEPTH(DEPTH), .MEM_TAP(MEM_TAP), .IO_TAP(IO_TAP)) u_wait (
        .clk(clk), .rst(rst), .as_n(as_n), .io_sel(addr_hi[1]),
        .ack0_n(ack0_n)
    );

    bpg_lane #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_lane (
        .cpu_wdata(cpu_wdata), .per_rdata(per_rdata),
        .per_wdata(per_wdata), .cpu_rdata(cpu_rdata)
    );

    assign rom_cs_n  = cs_n[RG_ROM];
    assign ram_cs_n  = cs_n[RG_RAM];
    assign disk_cs_n = cs_n[RG_DISK];
    assign uart_cs_n = cs_n[RG_UART];
    assign ack1_n    = 1'b1;

    p_ack1_high_r4: assert property (@(posedge clk) disable iff (rst)
        ack1_n);
    p_reset_quiet_r9: assert property (@(posedge clk)
        rst |-> (ack0_n && rd_n && wr_n && (&cs_n)));
endmodule

// File: tb/byte_port_glue_bench.sv
module byte_port_glue_bench;
    localparam int MT = 2;
    localparam int IT = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
    logic [1:0]  addr_hi = 2'd0, siz = 2'd0;
    logic [31:0] cpu_wdata = '0;
    logic [7:0]  per_rdata = '0;
    logic        rom_cs_n, ram_cs_n, disk_cs_n, uart_cs_n;
    logic        rd_n, wr_n, ack0_n, ack1_n;
    logic [7:0]  per_wdata;
    logic [31:0] cpu_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    byte_port_glue #(.MEM_TAP(MT), .IO_TAP(IT)) u_byte_port_glue (
        .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .addr_hi(addr_hi), .siz(siz), .cpu_wdata(cpu_wdata),
        .per_rdata(per_rdata), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n),
        .disk_cs_n(disk_cs_n), .uart_cs_n(uart_cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .ack0_n(ack0_n), .ack1_n(ack1_n),
        .per_wdata(per_wdata), .cpu_rdata(cpu_rdata)
    );

    function automatic logic [3:0] exp_cs(logic as_l, logic [1:0] rg);
        return as_l ? 4'hF : ~(4'b0001 << rg);
    endfunction

    function automatic logic [1:0] exp_strobes(logic ds_l, logic r);
        // {rd_n, wr_n}
        if (ds_l) return 2'b11;
        return r ? 2'b01 : 2'b10;
    endfunction

    function automatic int exp_edges(logic [1:0] rg);
        return (rg[1] ? IT : MT) + 1;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic chk_static(string tag);
        logic [3:0] cs;
        cs = {uart_cs_n, disk_cs_n, ram_cs_n, rom_cs_n};
        chk(cs == exp_cs(as_n, addr_hi), {"R1/R2 cs ", tag}, 32'(cs), 32'(exp_cs(as_n, addr_hi)));
        chk({rd_n, wr_n} == exp_strobes(ds_n, rw), {"R3 strobes ", tag},
            32'({rd_n, wr_n}), 32'(exp_strobes(ds_n, rw)));
        chk(ack1_n == 1'b1, {"R4 ack1 ", tag}, 32'(ack1_n), 32'd1);
        chk(per_wdata == cpu_wdata[31:24], {"R8 wlane ", tag}, 32'(per_wdata), 32'(cpu_wdata[31:24]));
        chk(cpu_rdata == {per_rdata, 24'h0}, {"R8 rlane ", tag}, cpu_rdata, {per_rdata, 24'h0});
    endtask

    task automatic access(logic [1:0] rg, logic r, logic use_ds, int hold);
        int seen;
        seen = 0;
        @(negedge clk);
        addr_hi   = rg;
        rw        = r;
        siz       = 2'($urandom);
        cpu_wdata = $urandom;
        per_rdata = 8'($urandom);
        as_n      = 1'b0;
        ds_n      = ~use_ds;
        #1;
        chk_static("start");
        chk(ack0_n == 1'b1, "R6 no ack before edge", 32'(ack0_n), 32'd1);
        for (int k = 1; k <= 12; k++) begin
            @(posedge clk);
            @(negedge clk);
            siz = 2'($urandom);  // R5: size lines toggled mid-cycle
            #1;
            if (!ack0_n) begin
                seen = k;
                break;
            end
        end
        chk(seen == exp_edges(rg), "R6 wait edges", 32'(seen), 32'(exp_edges(rg)));
        chk_static("acked R5");
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            siz = 2'($urandom);
            #1;
            chk(ack0_n == 1'b0, "R10 ack held", 32'(ack0_n), 32'd0);
        end
        as_n = 1'b1;
        ds_n = 1'b1;
        #1;
        chk(ack0_n == 1'b1, "R7 ack release", 32'(ack0_n), 32'd1);
        chk_static("end R2");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R9: reset holds everything inactive even with strobes low
        @(negedge clk);
        as_n = 1'b0; ds_n = 1'b0; rw = 1'b0; addr_hi = 2'd1;
        repeat (3) begin
            @(negedge clk);
            chk({rom_cs_n, ram_cs_n, disk_cs_n, uart_cs_n, rd_n, wr_n, ack0_n, ack1_n} == 8'hFF,
                "R9 reset quiet",
                32'({rom_cs_n, ram_cs_n, disk_cs_n, uart_cs_n, rd_n, wr_n, ack0_n, ack1_n}), 32'hFF);
        end
        as_n = 1'b1; ds_n = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk_static("idle R2");

        // Directed: every region, both directions, R1 and R6
        for (int rg = 0; rg < 4; rg++) begin
            access(2'(rg), 1'b1, 1'b1, 1);
            access(2'(rg), 1'b0, 1'b1, 0);
        end
        // R3: address strobe without data strobe
        access(2'd1, 1'b1, 1'b0, 1);
        // R7: back-to-back cycles restart the count
        access(2'd3, 1'b1, 1'b1, 0);
        access(2'd3, 1'b1, 1'b1, 0);
        access(2'd0, 1'b0, 1'b1, 0);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            access(2'($urandom), 1'($urandom), 1'($urandom_range(0, 3) != 0),
                   int'($urandom_range(0, 3)));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got=%h exp=%h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule